// File: doc/BRIEF.md
# Timer-Only Standby Entry and Wake Controller

This block is the power-state sequencer of a small microcontroller. Software asks for a low-power state in which only the main oscillator and the time-base timer keep running. The block accepts the request only when the clock system is in a mode that allows it. While the device is in standby, the block holds the CPU and peripheral clocks off and chooses whether the external pins hold their value or float. It also decides which low-speed oscillators keep running, which keeps the watch prescaler and the watchdog supplied when they are configured to run.

The block leaves standby on a reset event or on an interrupt from an enabled source. When the flash needs to recover, it passes through a sleep phase of a fixed, parameterised length before the CPU clock returns. That phase is skipped when code executes from RAM, or when the deep-standby control bit is set. All outputs are registered, and each one changes on the same clock edge as the state it reflects.

Top module: `stby_wake_ctrl`

## Requirements
- R1: A standby request is a cycle with `req_we` = 1 and `req_data` = 1 while the state is run. It takes effect on the next edge only when `clk_mode` is 3'b010, 3'b110 or 3'b111. Under any other code, or with `req_data` = 0, the state stays run.
- R2: `pwr_state` encodes run as 2'b00, standby as 2'b01 and recovery-sleep as 2'b10. `busy` is 1 exactly when the state is not run. After a synchronous reset the state is run and `busy` is 0.
- R3: In standby, `cpu_clk_en` and `periph_clk_en` are 0 and `tbt_clk_en` is 1. In run, all three are 1.
- R4: In standby, `pin_hiz` equals the value `pin_float_sel` had in the cycle the request was accepted. Later changes to `pin_float_sel` do not alter it during that stay. Outside standby, `pin_hiz` is 0.
- R5: `sub_xtal_clk_en` and `wpre_clk_en` follow `sub_xtal_cfg` one edge later, in every state. Outside standby, `sub_rc_clk_en` follows `sub_rc_cfg` one edge later.
- R6: In standby with `wdt_stby_en` = 1, `sub_rc_clk_en` is 1 whatever the value of `sub_rc_cfg`.
- R7: In standby, `wake_rst`, `tbt_irq` or `ext_irq` at 1 leaves standby on the next edge. `wpre_irq` does so only while `sub_xtal_cfg` = 1. With `sub_xtal_cfg` = 0, `wpre_irq` leaves the state in standby.
- R8: On a wake with `deep_stby_ctl` = 0 and `ram_exec` = 0, the state becomes recovery-sleep for exactly `FLASH_WAIT` cycles, with `cpu_clk_en` and `periph_clk_en` at 0. On the following edge the state becomes run and `cpu_clk_en` becomes 1.
- R9: On a wake with `deep_stby_ctl` = 1 or `ram_exec` = 1, the state goes from standby directly to run on the wake edge.
- R10: `wake_rst` during recovery-sleep restarts the full `FLASH_WAIT` wait, counted from that edge. `tbt_irq`, `ext_irq` and `wpre_irq` during recovery-sleep have no effect on its length.
- R11: In run, the wake inputs have no effect: the state stays run and the CPU and peripheral clock enables stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_we | input | 1 | Write strobe of the standby-request bit |
| req_data | input | 1 | Value written to the standby-request bit |
| clk_mode | input | MODE_W | Current clock-mode code |
| sub_xtal_cfg | input | 1 | Subclock oscillator enable setting |
| sub_rc_cfg | input | 1 | Low-speed RC oscillator enable setting |
| pin_float_sel | input | 1 | 1: pins float in standby, 0: pins hold |
| deep_stby_ctl | input | 1 | 1: skip the flash recovery sleep |
| ram_exec | input | 1 | Code runs from RAM; skip the flash recovery sleep |
| wdt_stby_en | input | 1 | Watchdog configured to run during standby |
| wake_rst | input | 1 | Reset wake event |
| tbt_irq | input | 1 | Time-base timer interrupt |
| ext_irq | input | 1 | External interrupt |
| wpre_irq | input | 1 | Watch prescaler interrupt |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| tbt_clk_en | output | 1 | Time-base timer clock enable |
| wpre_clk_en | output | 1 | Watch prescaler clock enable |
| sub_xtal_clk_en | output | 1 | Subclock oscillator enable |
| sub_rc_clk_en | output | 1 | Low-speed RC oscillator (watchdog clock) enable |
| pin_hiz | output | 1 | External pins high-impedance control |
| busy | output | 1 | Not in run state |
| pwr_state | output | 2 | Encoded power state |

## Verification
The bench applies every clock-mode code in turn. A filter that decodes too few or too many codes would then refuse an allowed request or enter standby from a forbidden mode. It times the recovery sleep to the exact edge, so a counter that is off by one would return the CPU clock one cycle early or late. A reset event is injected in the middle of the wait, which catches a design that ignores it or only resumes the old count, and so wakes too soon. Further stimulus raises a watch-prescaler interrupt with the subclock off, changes the float select during standby, and takes the RAM-execution and deep-standby bypass paths. These catch spurious wakes, pins that follow the live select bit, and needless sleep phases.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    PS_RUN  = 2'b00,
    PS_STBY = 2'b01,
    PS_RCVR = 2'b10
  } pwr_state_t;
endpackage

// File: rtl/stby_entry_qual.sv
module stby_entry_qual #(
  parameter int MODE_W = 3,
  parameter logic [(1<<MODE_W)-1:0] ALLOW_MASK = 8'b1100_0100
) (
  input  logic              in_run,
  input  logic              req_we,
  input  logic              req_data,
  input  logic [MODE_W-1:0] clk_mode,
  output logic              enter_req
);
  localparam int NMODE = 1 << MODE_W;

  logic [NMODE-1:0] hit;

  // one comparator per legal code; disallowed codes compare to zero
  for (genvar g = 0; g < NMODE; g++) begin : g_mode
    if (ALLOW_MASK[g]) begin : g_on
      assign hit[g] = (clk_mode == MODE_W'(g));
    end else begin : g_off
      assign hit[g] = 1'b0;
    end
  end

  assign enter_req = in_run && req_we && req_data && (|hit);
endmodule

// File: rtl/stby_wake_qual.sv
module stby_wake_qual (
  input  logic wake_rst,
  input  logic tbt_irq,
  input  logic ext_irq,
  input  logic wpre_irq,
  input  logic sub_xtal_cfg,
  output logic wake_any,
  output logic wake_reset
);
  localparam int NSRC = 4;

  logic [NSRC-1:0] src;
  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] live;

  assign src    = {wpre_irq, ext_irq, tbt_irq, wake_rst};
  // the watch prescaler only counts while the subclock runs
  assign src_en = {sub_xtal_cfg, 1'b1, 1'b1, 1'b1};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign live[s] = src[s] & src_en[s];
  end

  assign wake_any   = |live;
  assign wake_reset = live[0];
endmodule

// File: rtl/stby_rcvr_timer.sv
module stby_rcvr_timer #(
  parameter int FLASH_WAIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(FLASH_WAIT + 1);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(FLASH_WAIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= TOP;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R8: the wait counter never leaves its loaded range
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);

  // R10: a reload always lands on the full count
  assert_reload_full_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == TOP);
endmodule

// File: rtl/stby_clk_gates.sv
module stby_clk_gates
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pwr_state_t nxt_state,
  input  logic       entering,
  input  logic       sub_xtal_cfg,
  input  logic       sub_rc_cfg,
  input  logic       wdt_stby_en,
  input  logic       pin_float_sel,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       tbt_clk_en,
  output logic       wpre_clk_en,
  output logic       sub_xtal_clk_en,
  output logic       sub_rc_clk_en,
  output logic       pin_hiz
);
  logic float_lat;
  logic float_now;
  logic nxt_stby;
  logic nxt_run;

  assign nxt_stby  = (nxt_state == PS_STBY);
  assign nxt_run   = (nxt_state == PS_RUN);
  assign float_now = entering ? pin_float_sel : float_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      float_lat       <= 1'b0;
      cpu_clk_en      <= 1'b1;
      periph_clk_en   <= 1'b1;
      tbt_clk_en      <= 1'b1;
      wpre_clk_en     <= 1'b0;
      sub_xtal_clk_en <= 1'b0;
      sub_rc_clk_en   <= 1'b0;
      pin_hiz         <= 1'b0;
    end else begin
      if (entering) float_lat <= pin_float_sel;
      cpu_clk_en      <= nxt_run;
      periph_clk_en   <= nxt_run;
      tbt_clk_en      <= 1'b1;
      sub_xtal_clk_en <= sub_xtal_cfg;
      wpre_clk_en     <= sub_xtal_cfg;
      sub_rc_clk_en   <= sub_rc_cfg | (nxt_stby & wdt_stby_en);
      pin_hiz         <= nxt_stby & float_now;
    end
  end

  // R5: prescaler clock never runs without the subclock
  assert_wpre_needs_xtal_R5: assert property (@(posedge clk) disable iff (rst)
    wpre_clk_en |-> sub_xtal_clk_en);
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int MODE_W = 3,
  parameter logic [(1<<MODE_W)-1:0] ALLOW_MASK = 8'b1100_0100,
  parameter int FLASH_WAIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_we,
  input  logic              req_data,
  input  logic [MODE_W-1:0] clk_mode,
  input  logic              sub_xtal_cfg,
  input  logic              sub_rc_cfg,
  input  logic              pin_float_sel,
  input  logic              deep_stby_ctl,
  input  logic              ram_exec,
  input  logic              wdt_stby_en,
  input  logic              wake_rst,
  input  logic              tbt_irq,
  input  logic              ext_irq,
  input  logic              wpre_irq,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              tbt_clk_en,
  output logic              wpre_clk_en,
  output logic              sub_xtal_clk_en,
  output logic              sub_rc_clk_en,
  output logic              pin_hiz,
  output logic              busy,
  output logic [1:0]        pwr_state
);
  pwr_state_t state_q, state_d;
  logic enter_req, wake_any, wake_reset, expired;
  logic tmr_load, tmr_run, need_rcvr;

  stby_entry_qual #(.MODE_W(MODE_W), .ALLOW_MASK(ALLOW_MASK)) u_entry (
    .in_run   (state_q == PS_RUN),
    .req_we   (req_we),
    .req_data (req_data),
    .clk_mode (clk_mode),
    .enter_req(enter_req)
  );

  stby_wake_qual u_wake (
    .wake_rst    (wake_rst),
    .tbt_irq     (tbt_irq),
    .ext_irq     (ext_irq),
    .wpre_irq    (wpre_irq),
    .sub_xtal_cfg(sub_xtal_cfg),
    .wake_any    (wake_any),
    .wake_reset  (wake_reset)
  );

  stby_rcvr_timer #(.FLASH_WAIT(FLASH_WAIT)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .run    (tmr_run),
    .expired(expired)
  );

  assign need_rcvr = !deep_stby_ctl && !ram_exec;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    unique case (state_q)
      PS_RUN: begin
        if (enter_req) state_d = PS_STBY;
      end
      PS_STBY: begin
        if (wake_any) begin
          if (need_rcvr) begin
            state_d  = PS_RCVR;
            tmr_load = 1'b1;
          end else begin
            state_d = PS_RUN;
          end
        end
      end
      PS_RCVR: begin
        // a reset event outranks expiry and restarts the wait
        if (wake_reset) tmr_load = 1'b1;
        else if (expired) state_d = PS_RUN;
      end
      default: state_d = PS_RUN;
    endcase
  end

  assign tmr_run = (state_q == PS_RCVR) && !tmr_load;

  always_ff @(posedge clk) begin
    if (rst) state_q <= PS_RUN;
    else     state_q <= state_d;
  end

  stby_clk_gates u_gates (
    .clk            (clk),
    .rst            (rst),
    .nxt_state      (state_d),
    .entering       (enter_req),
    .sub_xtal_cfg   (sub_xtal_cfg),
    .sub_rc_cfg     (sub_rc_cfg),
    .wdt_stby_en    (wdt_stby_en),
    .pin_float_sel  (pin_float_sel),
    .cpu_clk_en     (cpu_clk_en),
    .periph_clk_en  (periph_clk_en),
    .tbt_clk_en     (tbt_clk_en),
    .wpre_clk_en    (wpre_clk_en),
    .sub_xtal_clk_en(sub_xtal_clk_en),
    .sub_rc_clk_en  (sub_rc_clk_en),
    .pin_hiz        (pin_hiz)
  );

  assign pwr_state = state_q;
  assign busy      = (state_q != PS_RUN);

  // R1: a request under a forbidden clock mode leaves the state in run
  assert_entry_filter_R1: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b00 && req_we && req_data && !ALLOW_MASK[clk_mode])
      |=> pwr_state == 2'b00);

  // R2: the state register only ever holds the three legal codes
  assert_state_legal_R2: assert property (@(posedge clk) disable iff (rst)
    pwr_state != 2'b11);

  // R3: standby gates the CPU and peripherals while the time base runs
  assert_stby_gating_R3: assert property (@(posedge clk) disable iff (rst)
    pwr_state == 2'b01 |-> !cpu_clk_en && !periph_clk_en && tbt_clk_en);

  // R4: pins never float outside standby
  assert_hiz_only_stby_R4: assert property (@(posedge clk) disable iff (rst)
    pin_hiz |-> pwr_state == 2'b01);

  // R6: the watchdog clock survives standby when configured
  assert_wdt_clock_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b01 && $past(wdt_stby_en) && $past(pwr_state) == 2'b01)
      |-> sub_rc_clk_en);

  // R7: an external interrupt always ends standby on the next edge
  assert_ext_wake_R7: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b01 && ext_irq) |=> pwr_state != 2'b01);

  // R8: the CPU clock stays off for the whole recovery sleep
  assert_rcvr_cpu_off_R8: assert property (@(posedge clk) disable iff (rst)
    pwr_state == 2'b10 |-> !cpu_clk_en && !periph_clk_en);

  // R9: a bypassed wake goes straight to run
  assert_bypass_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b01 && tbt_irq && (deep_stby_ctl || ram_exec))
      |=> pwr_state == 2'b00);

  // R10: a reset event during recovery keeps the controller asleep
  assert_rcvr_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b10 && wake_rst) |=> pwr_state == 2'b10);

  // R11: run is left only for standby
  assert_run_exit_R11: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b00 && !req_we) |=> pwr_state == 2'b00);
endmodule

// File: tb/test_stby_wake_ctrl.sv
module test_stby_wake_ctrl;
  localparam int WAIT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_we = 0, req_data = 0;
  logic [2:0] clk_mode = 3'b010;
  logic sub_xtal_cfg = 0, sub_rc_cfg = 0, pin_float_sel = 0;
  logic deep_stby_ctl = 1, ram_exec = 0, wdt_stby_en = 0;
  logic wake_rst = 0, tbt_irq = 0, ext_irq = 0, wpre_irq = 0;
  logic cpu_clk_en, periph_clk_en, tbt_clk_en, wpre_clk_en;
  logic sub_xtal_clk_en, sub_rc_clk_en, pin_hiz, busy;
  logic [1:0] pwr_state;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  stby_wake_ctrl #(.FLASH_WAIT(WAIT)) i_stby_wake_ctrl (
    .clk(clk), .rst(rst), .req_we(req_we), .req_data(req_data),
    .clk_mode(clk_mode), .sub_xtal_cfg(sub_xtal_cfg), .sub_rc_cfg(sub_rc_cfg),
    .pin_float_sel(pin_float_sel), .deep_stby_ctl(deep_stby_ctl),
    .ram_exec(ram_exec), .wdt_stby_en(wdt_stby_en), .wake_rst(wake_rst),
    .tbt_irq(tbt_irq), .ext_irq(ext_irq), .wpre_irq(wpre_irq),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .tbt_clk_en(tbt_clk_en), .wpre_clk_en(wpre_clk_en),
    .sub_xtal_clk_en(sub_xtal_clk_en), .sub_rc_clk_en(sub_rc_clk_en),
    .pin_hiz(pin_hiz), .busy(busy), .pwr_state(pwr_state)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic request(input logic [2:0] mode, input logic data);
    clk_mode = mode; req_we = 1; req_data = data;
    tick();
    req_we = 0; req_data = 0;
  endtask

  task automatic wake_ext_direct();
    deep_stby_ctl = 1; ext_irq = 1;
    tick();
    ext_irq = 0;
  endtask

  task automatic t_reset();
    chk("R2 reset state", pwr_state, 0);
    chk("R2 reset busy", busy, 0);
    chk("R3 reset cpu en", cpu_clk_en, 1);
    chk("R3 reset periph en", periph_clk_en, 1);
    chk("R4 reset pin_hiz", pin_hiz, 0);
  endtask

  task automatic t_mode_filter();
    for (int m = 0; m < 8; m++) begin
      int exp_st;
      exp_st = (m == 2 || m == 6 || m == 7) ? 1 : 0;
      request(3'(m), 1'b1);
      chk($sformatf("R1 entry mode %0d", m), pwr_state, exp_st);
      if (exp_st == 1) begin
        wake_ext_direct();
        chk("R9 direct wake", pwr_state, 0);
      end
    end
    request(3'b110, 1'b0);
    chk("R1 write of zero ignored", pwr_state, 0);
  endtask

  task automatic t_standby_gates();
    pin_float_sel = 0;
    request(3'b111, 1'b1);
    chk("R2 standby code", pwr_state, 1);
    chk("R2 standby busy", busy, 1);
    chk("R3 cpu gated", cpu_clk_en, 0);
    chk("R3 periph gated", periph_clk_en, 0);
    chk("R3 tbt running", tbt_clk_en, 1);
    chk("R4 pins held", pin_hiz, 0);
    wake_ext_direct();
    chk("R3 cpu back in run", cpu_clk_en, 1);
  endtask

  task automatic t_pin_float();
    pin_float_sel = 1;
    request(3'b010, 1'b1);
    chk("R4 pins float", pin_hiz, 1);
    pin_float_sel = 0;
    tick();
    chk("R4 latched float select", pin_hiz, 1);
    wake_ext_direct();
    chk("R4 pins released in run", pin_hiz, 0);
  endtask

  task automatic t_subclock();
    sub_xtal_cfg = 0;
    tick();
    chk("R5 prescaler off", wpre_clk_en, 0);
    request(3'b010, 1'b1);
    wpre_irq = 1;
    tick();
    wpre_irq = 0;
    chk("R7 prescaler irq ignored without subclock", pwr_state, 1);
    sub_xtal_cfg = 1;
    tick();
    chk("R5 prescaler on", wpre_clk_en, 1);
    chk("R5 subclock on", sub_xtal_clk_en, 1);
    deep_stby_ctl = 1; wpre_irq = 1;
    tick();
    wpre_irq = 0;
    chk("R7 prescaler wake", pwr_state, 0);
    sub_xtal_cfg = 0;
    tick();
    chk("R5 subclock off", sub_xtal_clk_en, 0);
  endtask

  task automatic t_watchdog();
    sub_rc_cfg = 0; wdt_stby_en = 1;
    tick();
    chk("R5 rc off in run", sub_rc_clk_en, 0);
    request(3'b010, 1'b1);
    chk("R6 rc forced in standby", sub_rc_clk_en, 1);
    wake_ext_direct();
    chk("R5 rc released in run", sub_rc_clk_en, 0);
    wdt_stby_en = 0; sub_rc_cfg = 1;
    tick();
    chk("R5 rc follows cfg", sub_rc_clk_en, 1);
    sub_rc_cfg = 0;
    tick();
  endtask

  task automatic t_recovery();
    request(3'b010, 1'b1);
    deep_stby_ctl = 0; ram_exec = 0; tbt_irq = 1;
    tick();
    tbt_irq = 0;
    chk("R8 recovery entered", pwr_state, 2);
    chk("R8 cpu off in recovery", cpu_clk_en, 0);
    repeat (WAIT - 1) tick();
    chk("R8 still asleep at last wait cycle", pwr_state, 2);
    chk("R8 cpu still off", cpu_clk_en, 0);
    tick();
    chk("R8 run after wait", pwr_state, 0);
    chk("R8 cpu on after wait", cpu_clk_en, 1);
  endtask

  task automatic t_ram_skip();
    request(3'b110, 1'b1);
    deep_stby_ctl = 0; ram_exec = 1; ext_irq = 1;
    tick();
    ext_irq = 0; ram_exec = 0;
    chk("R9 ram exec skips recovery", pwr_state, 0);
    chk("R9 cpu on at once", cpu_clk_en, 1);
  endtask

  task automatic t_rcvr_restart();
    request(3'b010, 1'b1);
    deep_stby_ctl = 0; wake_rst = 1;
    tick();
    wake_rst = 0;
    chk("R7 reset event wakes", pwr_state, 2);
    repeat (2) tick();
    wake_rst = 1;
    tick();
    wake_rst = 0;
    ext_irq = 1;
    tick();
    ext_irq = 0;
    chk("R10 irq in recovery ignored", pwr_state, 2);
    repeat (WAIT - 2) tick();
    chk("R10 wait restarted", pwr_state, 2);
    tick();
    chk("R10 run after restarted wait", pwr_state, 0);
  endtask

  task automatic t_run_irq();
    tbt_irq = 1; ext_irq = 1; wake_rst = 1; wpre_irq = 1;
    repeat (2) tick();
    tbt_irq = 0; ext_irq = 0; wake_rst = 0; wpre_irq = 0;
    chk("R11 run unaffected", pwr_state, 0);
    chk("R11 cpu stays on", cpu_clk_en, 1);
    chk("R11 periph stays on", periph_clk_en, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_mode_filter();
    t_standby_gates();
    t_pin_float();
    t_subclock();
    t_watchdog();
    t_recovery();
    t_ram_skip();
    t_rcvr_restart();
    t_run_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule